// File: doc/BRIEF.md
# HDLC Serial Receiver with Address Filter

The block takes a serial bit stream, qualified by a bit-rate enable, and turns HDLC frames into a byte stream. It finds opening and closing flags, removes the zeros the transmitter inserted after runs of ones, spots abort runs and assembles bytes with the first received bit as bit 0. Each output byte is marked with end-of-packet on the last byte of a frame and with an abort mark when the frame was cut short or did not end on a byte boundary.

An optional filter looks at the first byte of each frame and compares it with a programmed station address. The comparison uses either seven or six upper bits, and each width has its own all-ones broadcast code. A receive-enable input starts and stops reception only at frame boundaries. A transparent mode bypasses framing completely and packs raw bits into bytes; in that mode the enable takes effect at once.

Top module: `hdlc_rx_filter`

## Requirements
- R1: While and after reset, `byte_valid_o`, `byte_o`, `eop_o` and `abort_o` are all zero.
- R2: The bit pattern 0x7E opens and closes frames. Adjacent flags with no data between them, and frames shorter than eight data bits, produce no output.
- R3: Inside a frame, a zero that follows five consecutive ones is removed. Bytes are built with the first received data bit in bit 0.
- R4: Each accepted byte is presented once the next byte of the frame completes. On the closing flag the last byte is presented with `eop_o`=1 and `abort_o`=0.
- R5: With `addr_chk_i`=0 every frame is accepted, whatever its first byte and whatever `addr_six_i` is.
- R6: With `addr_chk_i`=1 and `addr_six_i`=0, a frame is accepted only if bits 7:1 of its first byte equal `addr_reg_i[7:1]` or are all ones.
- R7: With `addr_chk_i`=1 and `addr_six_i`=1, a frame is accepted only if bits 7:2 of its first byte equal `addr_reg_i[7:2]` or are all ones.
- R8: A rejected frame produces no output at all, including its first byte.
- R9: Seven or more consecutive ones abort the frame. The pending byte is presented with `eop_o`=1 and `abort_o`=1, unfinished bits are dropped, and nothing more is presented until a new flag opens a frame.
- R10: If the closing flag arrives when the data bit count is not a multiple of eight, the last full byte is presented with `eop_o`=1 and `abort_o`=1.
- R11: A frame already open when `rx_en_i` falls is received to its end. A flag seen while `rx_en_i`=0 opens no frame.
- R12: With `transparent_i`=1 and `rx_en_i`=1, every eight bits form one byte, first bit in bit 0. No flag detection, zero removal or filtering is applied, and `eop_o` and `abort_o` stay 0.
- R13: With `transparent_i`=1, a low `rx_en_i` stops output at once and discards the partial byte. Reception restarts on a fresh byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Samples `rx_bit_i` on this clock when high |
| rx_bit_i | input | 1 | Serial receive data |
| rx_en_i | input | 1 | Receive enable |
| addr_chk_i | input | 1 | Turns on the address filter |
| addr_six_i | input | 1 | 1: compare six upper bits; 0: seven upper bits |
| transparent_i | input | 1 | Raw bit packing mode |
| addr_reg_i | input | 8 | Station address |
| byte_valid_o | output | 1 | One-cycle strobe for a received byte |
| byte_o | output | 8 | Received byte |
| eop_o | output | 1 | Last byte of the frame |
| abort_o | output | 1 | Frame aborted or not byte aligned |

## Verification
In transparent mode a byte appears two clocks after the edge that samples its eighth bit. In framed mode every bit passes through an eight-bit window, so a byte completes eight bits after its last bit. It is then held until the next byte completes, two clocks after that bit edge, or until the closing flag, three clocks after the flag's last bit. The bench holds each bit for four clocks and compares results in order through a scoreboard, so delay never matters. After each scenario it waits well past the longest delay and checks that no expected result is still outstanding.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_FIRST = 2'd1,
    ST_PASS  = 2'd2,
    ST_DROP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int unsigned DW  = 8,
  parameter int unsigned RUN = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          bit_i,
  input  logic          tp_mode_i,
  input  logic          tp_run_i,
  output logic          byte_v_o,
  output logic [DW-1:0] byte_o,
  output logic          flag_v_o,
  output logic          flag_odd_o,
  output logic          abort_v_o
);
  localparam int unsigned WIN = RUN + 3;
  localparam int unsigned OW  = $clog2(RUN + 3);
  localparam int unsigned CW  = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [WIN-1:0] FLAG_PAT = {1'b0, {(RUN+1){1'b1}}, 1'b0};

  logic [WIN-1:0] win_q, vld_q, win_n;
  logic [OW-1:0]  in_ones_q, out_ones_q;
  logic [DW-1:0]  sh_q, sh_nx, byte_q;
  logic [CW-1:0]  cnt_q, cnt_nx, cnt_after;
  logic           exit_bit, exit_vld, is_flag, is_abort, take, wrap, src;
  logic           byte_v_q, flag_pend_q, flag_v_q, flag_odd_q, abort_q;

  always_comb begin
    win_n     = {win_q[WIN-2:0], bit_i};
    exit_bit  = win_q[WIN-1];
    exit_vld  = vld_q[WIN-1];
    is_flag   = (win_n == FLAG_PAT);
    is_abort  = bit_i && (in_ones_q == OW'(RUN + 1));
    // stuffed zero: valid zero after RUN data ones
    take      = exit_vld && !((out_ones_q == OW'(RUN)) && !exit_bit);
    src       = tp_mode_i ? bit_i : exit_bit;
    sh_nx     = {src, sh_q[DW-1:1]};
    wrap      = (cnt_q == CW'(DW - 1));
    cnt_nx    = wrap ? '0 : cnt_q + 1'b1;
    cnt_after = take ? cnt_nx : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= '0;
      vld_q       <= '0;
      in_ones_q   <= '0;
      out_ones_q  <= '0;
      sh_q        <= '0;
      cnt_q       <= '0;
      byte_q      <= '0;
      byte_v_q    <= 1'b0;
      flag_pend_q <= 1'b0;
      flag_v_q    <= 1'b0;
      flag_odd_q  <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      byte_v_q    <= 1'b0;
      abort_q     <= 1'b0;
      flag_v_q    <= flag_pend_q;  // flag lags the last byte by one clock
      flag_pend_q <= 1'b0;
      if (tp_mode_i) begin
        vld_q      <= '0;
        in_ones_q  <= '0;
        out_ones_q <= '0;
        if (!tp_run_i) begin
          cnt_q <= '0;
        end else if (bit_en_i) begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_nx;
          if (wrap) begin
            byte_v_q <= 1'b1;
            byte_q   <= sh_nx;
          end
        end
      end else if (bit_en_i) begin
        win_q     <= win_n;
        in_ones_q <= !bit_i ? '0 :
                     (in_ones_q == OW'(RUN + 2)) ? in_ones_q : in_ones_q + 1'b1;
        if (is_abort) begin
          vld_q      <= '0;
          cnt_q      <= '0;
          out_ones_q <= '0;
          abort_q    <= 1'b1;
        end else begin
          vld_q <= is_flag ? '0 : {vld_q[WIN-2:0], 1'b1};
          if (take) begin
            sh_q  <= sh_nx;
            cnt_q <= cnt_nx;
            if (wrap) begin
              byte_v_q <= 1'b1;
              byte_q   <= sh_nx;
            end
            out_ones_q <= !exit_bit ? '0 :
                          (out_ones_q == OW'(RUN)) ? out_ones_q : out_ones_q + 1'b1;
          end else if (exit_vld) begin
            out_ones_q <= '0;
          end
          if (is_flag) begin
            flag_pend_q <= 1'b1;
            flag_odd_q  <= (cnt_after != '0);
            cnt_q       <= '0;
            out_ones_q  <= '0;
          end
        end
      end
    end
  end

  assign byte_v_o   = byte_v_q;
  assign byte_o     = byte_q;
  assign flag_v_o   = flag_v_q;
  assign flag_odd_o = flag_odd_q;
  assign abort_v_o  = abort_q;

  p_byte_after_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_v_q |-> $past(bit_en_i));
  p_flag_abort_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_v_q && abort_q));
endmodule

// File: rtl/hdlc_rx_addr_match.sv
module hdlc_rx_addr_match #(
  parameter int unsigned DW = 8
) (
  input  logic          chk_i,
  input  logic          six_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] rx_i,
  output logic          hit_o
);
  localparam logic [DW-1:0] MASK7 = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] MASK6 = {{(DW-2){1'b1}}, 2'b00};

  logic [DW-1:0] mask;
  logic          same, bcast;

  always_comb begin
    mask  = six_i ? MASK6 : MASK7;
    same  = ((rx_i ^ addr_i) & mask) == '0;
    bcast = (rx_i & mask) == mask;
    hit_o = !chk_i || same || bcast;
  end
endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter #(
  parameter int unsigned DW  = 8,
  parameter int unsigned RUN = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          rx_bit_i,
  input  logic          rx_en_i,
  input  logic          addr_chk_i,
  input  logic          addr_six_i,
  input  logic          transparent_i,
  input  logic [DW-1:0] addr_reg_i,
  output logic          byte_valid_o,
  output logic [DW-1:0] byte_o,
  output logic          eop_o,
  output logic          abort_o
);
  import hdlc_rx_pkg::*;

  logic          d_byte_v, d_flag_v, d_flag_odd, d_abort_v, hit;
  logic [DW-1:0] d_byte;
  rx_state_e     state_q, state_n;
  logic [DW-1:0] hold_q, hold_n, out_d_n;
  logic          emit_n, eop_n, ab_n;
  logic          out_v_q, out_eop_q, out_ab_q;
  logic [DW-1:0] out_d_q;

  hdlc_rx_deframer #(.DW(DW), .RUN(RUN)) u_deframer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .bit_i      (rx_bit_i),
    .tp_mode_i  (transparent_i),
    .tp_run_i   (transparent_i & rx_en_i),
    .byte_v_o   (d_byte_v),
    .byte_o     (d_byte),
    .flag_v_o   (d_flag_v),
    .flag_odd_o (d_flag_odd),
    .abort_v_o  (d_abort_v)
  );

  hdlc_rx_addr_match #(.DW(DW)) u_match (
    .chk_i  (addr_chk_i),
    .six_i  (addr_six_i),
    .addr_i (addr_reg_i),
    .rx_i   (d_byte),
    .hit_o  (hit)
  );

  always_comb begin
    state_n = state_q;
    hold_n  = hold_q;
    emit_n  = 1'b0;
    out_d_n = hold_q;
    eop_n   = 1'b0;
    ab_n    = 1'b0;
    if (transparent_i) begin
      state_n = ST_HUNT;
      if (d_byte_v && rx_en_i) begin
        emit_n  = 1'b1;
        out_d_n = d_byte;
      end
    end else if (d_abort_v) begin
      if (state_q == ST_PASS) begin
        emit_n = 1'b1;
        eop_n  = 1'b1;
        ab_n   = 1'b1;
      end
      state_n = ST_HUNT;
    end else if (d_flag_v) begin
      if (state_q == ST_PASS) begin
        emit_n = 1'b1;
        eop_n  = 1'b1;
        ab_n   = d_flag_odd;
      end
      // enable is honoured only here, at a frame boundary
      state_n = rx_en_i ? ST_FIRST : ST_HUNT;
    end else if (d_byte_v) begin
      unique case (state_q)
        ST_FIRST: begin
          state_n = hit ? ST_PASS : ST_DROP;
          hold_n  = d_byte;
        end
        ST_PASS: begin
          emit_n = 1'b1;
          hold_n = d_byte;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      hold_q    <= '0;
      out_v_q   <= 1'b0;
      out_d_q   <= '0;
      out_eop_q <= 1'b0;
      out_ab_q  <= 1'b0;
    end else begin
      state_q   <= state_n;
      hold_q    <= hold_n;
      out_v_q   <= emit_n;
      out_eop_q <= emit_n & eop_n;
      out_ab_q  <= emit_n & ab_n;
      if (emit_n) out_d_q <= out_d_n;
    end
  end

  assign byte_valid_o = out_v_q;
  assign byte_o       = out_d_q;
  assign eop_o        = out_eop_q;
  assign abort_o      = out_ab_q;

  p_abort_closes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (byte_valid_o && eop_o));
  p_drop_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |-> !byte_valid_o);
  p_no_byte_with_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(d_byte_v && (d_flag_v || d_abort_v)));
  p_tp_plain_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && $past(transparent_i)) |-> (!eop_o && !abort_o));
  p_tp_stop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(transparent_i && !rx_en_i) |-> !byte_valid_o);
endmodule

// File: tb/hdlc_rx_filter_bench.sv
`timescale 1ns/100ps
module hdlc_rx_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, rx_bit = 1'b1, rx_en = 1'b0;
  logic       addr_chk = 1'b0, addr_six = 1'b0, transp = 1'b0;
  logic [7:0] addr_reg = 8'h54;
  logic       byte_valid_o, eop_o, abort_o;
  logic [7:0] byte_o;

  typedef struct {
    logic [7:0] d;
    logic       eop;
    logic       ab;
    string      req;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0, n_fail = 0, tx_ones = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  hdlc_rx_filter u_hdlc_rx_filter (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .rx_bit_i(rx_bit),
    .rx_en_i(rx_en), .addr_chk_i(addr_chk), .addr_six_i(addr_six),
    .transparent_i(transp), .addr_reg_i(addr_reg),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .eop_o(eop_o), .abort_o(abort_o)
  );

  // monitor: pops the scoreboard on every output strobe
  always @(negedge clk) begin
    if (rst_n && byte_valid_o) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected byte %h eop %b abort %b, expected none",
                 cur_req, byte_o, eop_o, abort_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (byte_o !== e.d || eop_o !== e.eop || abort_o !== e.ab) begin
          n_fail++;
          $display("FAIL %s got byte %h eop %b abort %b, expected byte %h eop %b abort %b",
                   e.req, byte_o, eop_o, abort_o, e.d, e.eop, e.ab);
        end
      end
    end
  end

  task automatic push(input logic [7:0] d, input logic eop, input logic ab, input string req);
    exp_t e;
    e.d = d; e.eop = eop; e.ab = ab; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic raw_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic data_bit(input logic b);
    raw_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        raw_bit(1'b0);
        tx_ones = 0;
      end
    end else begin
      tx_ones = 0;
    end
  endtask

  task automatic tx_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) data_bit(b[i]);
  endtask

  task automatic raw_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) raw_bit(b[i]);
  endtask

  task automatic tx_flag();
    raw_byte(8'h7E);
    tx_ones = 0;
  endtask

  task automatic tx_abort();
    for (int i = 0; i < 8; i++) raw_bit(1'b1);
    tx_ones = 0;
  endtask

  task automatic drain(input string req);
    repeat (40) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s %0d results outstanding, expected 0", req, sb_q.size());
      sb_q.delete();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, expected run to finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (byte_valid_o !== 1'b0 || byte_o !== 8'h00 || eop_o !== 1'b0 || abort_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 outputs %b %h %b %b, expected 0 00 0 0",
               byte_valid_o, byte_o, eop_o, abort_o);
    end
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5: filter off, stuffed bytes, eop on last
    cur_req = "R3";
    for (int i = 0; i < 4; i++) raw_bit(1'b1);
    tx_flag();
    push(8'h12, 0, 0, "R4"); push(8'hFF, 0, 0, "R3"); push(8'h3E, 1, 0, "R4");
    tx_byte(8'h12); tx_byte(8'hFF); tx_byte(8'h3E);
    tx_flag();
    drain("R4");

    // R2: back-to-back flags and a short frame give nothing
    cur_req = "R2";
    tx_flag(); tx_flag(); tx_flag();
    data_bit(1); data_bit(0); data_bit(1);
    tx_flag();
    drain("R2");

    // R5: six-bit select ignored while filter off
    cur_req = "R5";
    addr_six = 1'b1;
    push(8'h00, 0, 0, "R5"); push(8'h77, 1, 0, "R5");
    tx_byte(8'h00); tx_byte(8'h77); tx_flag();
    drain("R5");

    // R6: seven-bit match, addr 0x54
    cur_req = "R6";
    addr_chk = 1'b1; addr_six = 1'b0;
    push(8'h55, 0, 0, "R6"); push(8'hA0, 1, 0, "R6");
    tx_byte(8'h55); tx_byte(8'hA0); tx_flag();
    cur_req = "R8";
    tx_byte(8'h56); tx_byte(8'hA1); tx_flag();
    tx_byte(8'hFC); tx_byte(8'hA2); tx_flag();
    cur_req = "R6";
    push(8'hFE, 0, 0, "R6"); push(8'hA3, 1, 0, "R6");
    tx_byte(8'hFE); tx_byte(8'hA3); tx_flag();
    drain("R8");

    // R7: six-bit match
    cur_req = "R7";
    addr_six = 1'b1;
    push(8'h57, 0, 0, "R7"); push(8'hB0, 1, 0, "R7");
    tx_byte(8'h57); tx_byte(8'hB0); tx_flag();
    push(8'hFC, 0, 0, "R7"); push(8'hB1, 1, 0, "R7");
    tx_byte(8'hFC); tx_byte(8'hB1); tx_flag();
    cur_req = "R8";
    tx_byte(8'h5A); tx_byte(8'hB2); tx_byte(8'hB3); tx_flag();
    drain("R7");
    addr_chk = 1'b0; addr_six = 1'b0;

    // R9: abort mid-frame, then a clean frame
    cur_req = "R9";
    push(8'hA1, 0, 0, "R9"); push(8'hB2, 1, 1, "R9");
    tx_byte(8'hA1); tx_byte(8'hB2); tx_byte(8'hC3);
    tx_abort();
    for (int i = 0; i < 4; i++) raw_bit(1'b1);
    drain("R9");
    tx_flag();
    push(8'h61, 1, 0, "R9");
    tx_byte(8'h61); tx_flag();
    drain("R9");

    // R10: residual bits before closing flag
    cur_req = "R10";
    push(8'h11, 0, 0, "R10"); push(8'h22, 1, 1, "R10");
    tx_byte(8'h11); tx_byte(8'h22);
    data_bit(1); data_bit(0); data_bit(1);
    tx_flag();
    drain("R10");

    // R11: enable dropped mid-frame
    cur_req = "R11";
    push(8'h31, 0, 0, "R11"); push(8'h32, 1, 0, "R11");
    tx_byte(8'h31);
    rx_en = 1'b0;
    tx_byte(8'h32); tx_flag();
    drain("R11");
    tx_byte(8'h41); tx_byte(8'h42); tx_flag();
    drain("R11");
    rx_en = 1'b1;
    tx_flag();
    push(8'h51, 1, 0, "R11");
    tx_byte(8'h51); tx_flag();
    drain("R11");

    // R12: transparent packing, no flags or zero removal
    cur_req = "R12";
    transp = 1'b1; rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    push(8'hA5, 0, 0, "R12"); push(8'h7E, 0, 0, "R12"); push(8'hFF, 0, 0, "R12");
    raw_byte(8'hA5); raw_byte(8'h7E); raw_byte(8'hFF);
    drain("R12");

    // R13: immediate stop and fresh restart
    cur_req = "R13";
    for (int i = 0; i < 4; i++) raw_bit(1'b1);
    rx_en = 1'b0;
    for (int i = 0; i < 12; i++) raw_bit(1'b0);
    drain("R13");
    rx_en = 1'b1;
    push(8'h96, 0, 0, "R13");
    raw_byte(8'h96);
    drain("R13");

    transp = 1'b0;
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule